// File: doc/BRIEF.md
# Command Reply Timeout and Validator

This block watches the receive side of a bus controller once a command has gone out. It measures the silence before a remote terminal answers and judges every word that comes back. The words arrive as events from a separate word decoder. Each event carries the sync type, flags for Manchester, parity and bit-count faults, and the sixteen data bits. When a message starts, the block takes in the settings for that message: which terminal should answer, how many data words should follow, whether the transfer runs between two terminals, and which status flags to ignore.

For a transfer between two terminals, the sending terminal's status comes first, then the data words, then the receiving terminal's status. Each reply has its own time limit. Every kind of fault sets its own bit in an error vector. These bits stay set until the next message starts. At the end of the message a one-cycle `done` pulse appears, and `pass` is high in that cycle only if no error bit is set.

Top module: `rt_reply_check`

## Requirements
- R1: `toSel` values 0, 1, 2 and 3 set the reply limit to 18, 22, 50 and 130 ticks of `usTick`. The limit counts ticks that arrive after `msgStart`. If no word has arrived by the limit-th tick, the block sets errVec bit 0 and pulses `done` right after that tick.
- R2: A status word that arrives before or on the limit-th tick is accepted, and a fault-free message then ends with `pass` high.
- R3: Bits 15:11 of a status word must equal the expected terminal address. A mismatch sets errVec bit 6.
- R4: A status word needs status sync (`wordSync`=1) and a data word needs data sync (`wordSync`=0). A wrong sync sets errVec bit 2.
- R5: On every accepted word, a Manchester fault sets errVec bit 3, a parity fault sets bit 4 and a bit-count fault sets bit 5.
- R6: Suppose data words are still owed and no word arrives for GAP_US (24) ticks. Then errVec bit 7 is set and `done` pulses on that tick.
- R7: After the final expected word, a word that arrives within GAP_US ticks sets errVec bit 7 and ends the message on that cycle. If no word arrives, `done` pulses on the GAP_US-th tick.
- R8: Any of status bits 10:0 that is set and not masked by `flagMask` sets errVec bit 8. Masked bits have no effect.
- R9: When `rtToRt`=1, the first status is checked against `txAddr` and the second against `cmdAddr`. The limit for the second status runs from the last data word. A missing second status sets errVec bit 1.
- R10: Error bits are sticky within a message and are all cleared by `msgStart`. `done` lasts exactly one cycle, `pass` = `done` with no error bit set, and `errVec` holds its value after `done`.
- R11: After reset, `done`, `pass` and `errVec` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| usTick | input | 1 | One-cycle pulse per microsecond |
| msgStart | input | 1 | Command sent; latch settings, start timing |
| toSel | input | 2 | Reply limit select |
| rtToRt | input | 1 | Transfer between two terminals |
| cmdAddr | input | 5 | Addressed (receiving) terminal |
| txAddr | input | 5 | Sending terminal for terminal-to-terminal transfers |
| expWords | input | 6 | Data words expected on the receive path |
| flagMask | input | 11 | Status flag bits to ignore |
| wordValid | input | 1 | Decoded word event |
| wordSync | input | 1 | 1 = status sync, 0 = data sync |
| wordManErr | input | 1 | Manchester fault on the word |
| wordParErr | input | 1 | Parity fault on the word |
| wordBitErr | input | 1 | Bit-count fault on the word |
| wordData | input | 16 | Word contents |
| done | output | 1 | Message finished (one cycle) |
| pass | output | 1 | Finished with no error |
| errVec | output | 9 | Sticky error bits |

## Verification
If the timer is wrong, the timeout `done` shows up one tick early or late. The bench probes the limit-1 and limit tick boundaries for every select value, so this is caught at once. If the word counter or the state sequence is wrong, data words get treated as status words or the reverse. That shows up in the very next message as a spurious sync, address or word-count bit. A bad clear or a lost sticky bit shows up as a wrong `errVec` on the following `done`.

// File: rtl/rtv_pkg.sv
package rtv_pkg;
  localparam int ERR_W    = 9;
  localparam int ERR_TO1  = 0;
  localparam int ERR_TO2  = 1;
  localparam int ERR_SYNC = 2;
  localparam int ERR_MAN  = 3;
  localparam int ERR_PAR  = 4;
  localparam int ERR_BIT  = 5;
  localparam int ERR_ADDR = 6;
  localparam int ERR_WC   = 7;
  localparam int ERR_FLAG = 8;
  localparam int TMR_W    = 8;

  typedef struct packed {
    logic clr;
    logic chkStat;
    logic chkData;
    logic useTx;
    logic setTo1;
    logic setTo2;
    logic setWc;
  } strobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_STAT1, S_DATA, S_STAT2, S_TAIL
  } state_t;

  function automatic logic [TMR_W-1:0] respLimit(input logic [1:0] sel);
    case (sel)
      2'd0:    respLimit = TMR_W'(18);
      2'd1:    respLimit = TMR_W'(22);
      2'd2:    respLimit = TMR_W'(50);
      default: respLimit = TMR_W'(130);
    endcase
  endfunction
endpackage

// File: rtl/rtv_ctrl.sv
module rtv_ctrl
  import rtv_pkg::*;
#(
  parameter int WC_W   = 6,
  parameter int GAP_US = 24
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            usTick,
  input  logic            msgStart,
  input  logic [1:0]      toSel,
  input  logic [WC_W-1:0] expWords,
  input  logic            rtToRt,
  input  logic            wordValid,
  output strobe_t         stb,
  output logic            done
);
  state_t            state, nxt;
  logic [1:0]        selQ;
  logic [WC_W-1:0]   wordsQ, remain;
  logic              rtrtQ;
  logic [TMR_W-1:0]  cnt, curLimit;
  logic              expire, restart, finish;

  always_comb begin
    if (state == S_DATA || state == S_TAIL) curLimit = TMR_W'(GAP_US);
    else                                    curLimit = respLimit(selQ);
  end

  assign expire = usTick && (cnt == curLimit - TMR_W'(1));

  always_comb begin
    stb     = '0;
    nxt     = state;
    finish  = 1'b0;
    restart = 1'b0;
    if (msgStart) begin
      stb.clr = 1'b1;
      restart = 1'b1;
      nxt     = S_STAT1;
    end else begin
      case (state)
        S_STAT1: begin
          if (wordValid) begin
            stb.chkStat = 1'b1;
            stb.useTx   = rtrtQ;
            restart     = 1'b1;
            if (wordsQ != '0) nxt = S_DATA;
            else if (rtrtQ)   nxt = S_STAT2;
            else              nxt = S_TAIL;
          end else if (expire) begin
            stb.setTo1 = 1'b1;
            finish     = 1'b1;
            nxt        = S_IDLE;
          end
        end
        S_DATA: begin
          if (wordValid) begin
            stb.chkData = 1'b1;
            restart     = 1'b1;
            if (remain == WC_W'(1)) nxt = rtrtQ ? S_STAT2 : S_TAIL;
          end else if (expire) begin
            stb.setWc = 1'b1;
            finish    = 1'b1;
            nxt       = S_IDLE;
          end
        end
        S_STAT2: begin
          if (wordValid) begin
            stb.chkStat = 1'b1;
            restart     = 1'b1;
            nxt         = S_TAIL;
          end else if (expire) begin
            stb.setTo2 = 1'b1;
            finish     = 1'b1;
            nxt        = S_IDLE;
          end
        end
        S_TAIL: begin
          if (wordValid) begin
            stb.setWc = 1'b1;
            finish    = 1'b1;
            nxt       = S_IDLE;
          end else if (expire) begin
            finish = 1'b1;
            nxt    = S_IDLE;
          end
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      done   <= 1'b0;
      cnt    <= '0;
      selQ   <= '0;
      wordsQ <= '0;
      remain <= '0;
      rtrtQ  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= finish;
      if (restart)                        cnt <= '0;
      else if (usTick && state != S_IDLE) cnt <= cnt + TMR_W'(1);
      if (msgStart) begin
        selQ   <= toSel;
        wordsQ <= expWords;
        remain <= expWords;
        rtrtQ  <= rtToRt;
      end else if (state == S_DATA && wordValid) begin
        remain <= remain - WC_W'(1);
      end
    end
  end
endmodule

// File: rtl/rtv_dp.sv
module rtv_dp
  import rtv_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int FLAG_W = 11,
  localparam int WORD_W = ADDR_W + FLAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [ADDR_W-1:0] txAddr,
  input  logic [FLAG_W-1:0] flagMask,
  input  logic              wordSync,
  input  logic              wordManErr,
  input  logic              wordParErr,
  input  logic              wordBitErr,
  input  logic [WORD_W-1:0] wordData,
  output logic [ERR_W-1:0]  errVec
);
  logic [ADDR_W-1:0] cmdQ, txQ, expAddr;
  logic [FLAG_W-1:0] maskQ;
  logic [ERR_W-1:0]  hit;
  logic              anyChk;

  assign anyChk  = stb.chkStat || stb.chkData;
  assign expAddr = stb.useTx ? txQ : cmdQ;

  always_comb begin
    hit           = '0;
    hit[ERR_TO1]  = stb.setTo1;
    hit[ERR_TO2]  = stb.setTo2;
    hit[ERR_WC]   = stb.setWc;
    hit[ERR_SYNC] = (stb.chkStat && !wordSync) || (stb.chkData && wordSync);
    hit[ERR_MAN]  = anyChk && wordManErr;
    hit[ERR_PAR]  = anyChk && wordParErr;
    hit[ERR_BIT]  = anyChk && wordBitErr;
    hit[ERR_ADDR] = stb.chkStat && (wordData[WORD_W-1 -: ADDR_W] != expAddr);
    hit[ERR_FLAG] = stb.chkStat && ((wordData[FLAG_W-1:0] & ~maskQ) != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errVec <= '0;
      cmdQ   <= '0;
      txQ    <= '0;
      maskQ  <= '0;
    end else if (stb.clr) begin
      errVec <= '0;
      cmdQ   <= cmdAddr;
      txQ    <= txAddr;
      maskQ  <= flagMask;
    end else begin
      errVec <= errVec | hit;
    end
  end
endmodule

// File: rtl/rt_reply_check.sv
module rt_reply_check
  import rtv_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int FLAG_W = 11,
  parameter int WC_W   = 6,
  parameter int GAP_US = 24,
  localparam int WORD_W = ADDR_W + FLAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              msgStart,
  input  logic [1:0]        toSel,
  input  logic              rtToRt,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [ADDR_W-1:0] txAddr,
  input  logic [WC_W-1:0]   expWords,
  input  logic [FLAG_W-1:0] flagMask,
  input  logic              wordValid,
  input  logic              wordSync,
  input  logic              wordManErr,
  input  logic              wordParErr,
  input  logic              wordBitErr,
  input  logic [WORD_W-1:0] wordData,
  output logic              done,
  output logic              pass,
  output logic [ERR_W-1:0]  errVec
);
  strobe_t stb;

  rtv_ctrl #(.WC_W(WC_W), .GAP_US(GAP_US)) u_ctrl (
    .clk(clk), .rstN(rstN), .usTick(usTick), .msgStart(msgStart),
    .toSel(toSel), .expWords(expWords), .rtToRt(rtToRt),
    .wordValid(wordValid), .stb(stb), .done(done)
  );

  rtv_dp #(.ADDR_W(ADDR_W), .FLAG_W(FLAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdAddr(cmdAddr), .txAddr(txAddr),
    .flagMask(flagMask), .wordSync(wordSync), .wordManErr(wordManErr),
    .wordParErr(wordParErr), .wordBitErr(wordBitErr), .wordData(wordData),
    .errVec(errVec)
  );

  assign pass = done && (errVec == '0);
endmodule

// File: rtl/rtv_sva.sv
module rtv_sva
  import rtv_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             msgStart,
  input logic             wordValid,
  input logic             done,
  input logic [ERR_W-1:0] errVec
);
  localparam logic [ERR_W-1:0] WORD_ERRS =
    ERR_W'((1 << ERR_SYNC) | (1 << ERR_MAN) | (1 << ERR_PAR) |
           (1 << ERR_BIT) | (1 << ERR_ADDR) | (1 << ERR_FLAG));

  // R1: a first-reply timeout always ends the message
  a_r1_timeout_ends: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errVec[ERR_TO1]) |-> done);

  // R9: a second-reply timeout always ends the message
  a_r9_second_timeout_ends: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errVec[ERR_TO2]) |-> done);

  // R6: a word-count fault always ends the message
  a_r6_count_fault_ends: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errVec[ERR_WC]) |-> done);

  // R5: word-level faults appear only after a word event
  a_r5_word_faults_need_word: assert property (@(posedge clk) disable iff (!rstN)
    ((errVec & ~$past(errVec) & WORD_ERRS) != '0) |-> $past(wordValid));

  // R10: a new message clears every error bit
  a_r10_clear_on_start: assert property (@(posedge clk) disable iff (!rstN)
    msgStart |=> (errVec == '0));

  // R10: bits never drop without a message start
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !$past(msgStart) |-> (($past(errVec) & ~errVec) == '0));

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

bind rt_reply_check rtv_sva u_sva (.*);

// File: tb/tb_rt_reply_check.sv
module tb_rt_reply_check;
  localparam int GAP = 24;
  localparam int B_TO1 = 0, B_TO2 = 1, B_SYNC = 2, B_MAN = 3, B_PAR = 4;
  localparam int B_BIT = 5, B_ADDR = 6, B_WC = 7, B_FLAG = 8;

  logic clk = 1'b0, rstN = 1'b0, usTick = 1'b0, msgStart = 1'b0;
  logic [1:0] toSel = '0;
  logic rtToRt = 1'b0;
  logic [4:0] cmdAddr = '0, txAddr = '0;
  logic [5:0] expWords = '0;
  logic [10:0] flagMask = '0;
  logic wordValid = 1'b0, wordSync = 1'b0, wordManErr = 1'b0;
  logic wordParErr = 1'b0, wordBitErr = 1'b0;
  logic [15:0] wordData = '0;
  logic done, pass;
  logic [8:0] errVec;

  int errs = 0, checks = 0, tickCnt = 0;
  bit finished = 0;

  rt_reply_check dut (.*);

  always #2 clk = ~clk;

  initial begin
    forever begin
      repeat (4) @(negedge clk);
      usTick = 1'b1;
      @(negedge clk);
      usTick = 1'b0;
    end
  end

  always @(posedge clk) if (usTick) tickCnt <= tickCnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitTicks(input int n);
    int tgt;
    tgt = tickCnt + n;
    while (tickCnt < tgt) @(negedge clk);
  endtask

  function automatic int limOf(input int sel);
    case (sel)
      0: return 18;
      1: return 22;
      2: return 50;
      default: return 130;
    endcase
  endfunction

  task automatic startMsg(input int sel, input int words, input bit rtrt,
                          input logic [4:0] ca, input logic [4:0] ta,
                          input logic [10:0] mask);
    waitTicks(1);
    toSel = sel[1:0]; expWords = words[5:0]; rtToRt = rtrt;
    cmdAddr = ca; txAddr = ta; flagMask = mask; msgStart = 1'b1;
    @(negedge clk);
    msgStart = 1'b0;
  endtask

  task automatic sendWord(input bit sync, input bit man, input bit par,
                          input bit bitc, input logic [15:0] d);
    wordValid = 1'b1; wordSync = sync; wordManErr = man;
    wordParErr = par; wordBitErr = bitc; wordData = d;
    @(negedge clk);
    wordValid = 1'b0; wordManErr = 1'b0; wordParErr = 1'b0; wordBitErr = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int n;
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " done seen"}, done, 1);
  endtask

  task automatic sendData(input int n);
    for (int k = 0; k < n; k++) begin
      waitTicks(2);
      sendWord(0, 0, 0, 0, 16'(k * 37 + 5));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 done", done, 0);
    chk("R11 pass", pass, 0);
    chk("R11 errVec", errVec, 0);

    // R1: timeout boundary for each select value
    for (int s = 0; s < 4; s++) begin
      startMsg(s, 0, 0, 5'd5, 5'd0, 11'd0);
      chk("R10 cleared after start", errVec, 0);
      waitTicks(limOf(s) - 1);
      chk("R1 no timeout before limit", done, 0);
      waitTicks(1);
      chk("R1 timeout done at limit", done, 1);
      chk("R1 timeout bit", errVec, 1 << B_TO1);
      chk("R1 no pass on timeout", pass, 0);
    end

    // R2/R7/R10: reply on the last allowed tick, then tail timing
    for (int s = 0; s < 4; s++) begin
      startMsg(s, 0, 0, 5'd5, 5'd0, 11'd0);
      waitTicks(limOf(s) - 1);
      sendWord(1, 0, 0, 0, {5'd5, 11'd0});
      waitTicks(GAP - 1);
      chk("R7 no done inside tail", done, 0);
      waitTicks(1);
      chk("R7 done at tail end", done, 1);
      chk("R2 pass", pass, 1);
      chk("R2 errVec", errVec, 0);
      @(negedge clk);
      chk("R10 done one cycle", done, 0);
      chk("R10 errVec held", errVec, 0);
    end

    // R3: address sweep
    for (int a = 0; a < 32; a++) begin
      startMsg(a % 4, 0, 0, 5'(a), 5'd0, 11'd0);
      waitTicks(3);
      sendWord(1, 0, 0, 0, {5'(a), 11'd0});
      waitDone("R3 match");
      chk("R3 match errVec", errVec, 0);
      startMsg(a % 4, 0, 0, 5'(a), 5'd0, 11'd0);
      waitTicks(3);
      sendWord(1, 0, 0, 0, {5'(a) ^ 5'(1 << (a % 5)), 11'd0});
      waitDone("R3 mismatch");
      chk("R3 mismatch errVec", errVec, 1 << B_ADDR);
    end

    // R4/R5: faults on the status word
    for (int f = 0; f < 4; f++) begin
      startMsg(0, 0, 0, 5'd7, 5'd0, 11'd0);
      waitTicks(2);
      sendWord(f != 0, f == 1, f == 2, f == 3, {5'd7, 11'd0});
      waitDone("R5 status fault");
      chk(f == 0 ? "R4 status sync" : "R5 status word fault", errVec,
          f == 0 ? (1 << B_SYNC) : f == 1 ? (1 << B_MAN) :
          f == 2 ? (1 << B_PAR) : (1 << B_BIT));
    end
    startMsg(1, 0, 0, 5'd7, 5'd0, 11'd0);
    waitTicks(2);
    sendWord(1, 0, 1, 0, {5'd8, 11'd0});
    waitDone("R10 accumulate");
    chk("R10 two bits accumulate", errVec, (1 << B_PAR) | (1 << B_ADDR));

    // R6/R7: data word counts
    for (int i = 0; i < 4; i++) begin
      int n;
      n = (i == 0) ? 1 : (i == 1) ? 2 : (i == 2) ? 7 : 32;
      startMsg(2, n, 0, 5'd3, 5'd0, 11'd0);
      waitTicks(4);
      sendWord(1, 0, 0, 0, {5'd3, 11'd0});
      sendData(n);
      waitDone("R7 exact count");
      chk("R7 exact count errVec", errVec, 0);
      chk("R7 exact count pass", pass, 1);

      startMsg(2, n, 0, 5'd3, 5'd0, 11'd0);
      waitTicks(4);
      sendWord(1, 0, 0, 0, {5'd3, 11'd0});
      sendData(n - 1);
      waitTicks(GAP - 1);
      chk("R6 no done before gap", done, 0);
      waitTicks(1);
      chk("R6 done on gap", done, 1);
      chk("R6 too few errVec", errVec, 1 << B_WC);

      startMsg(2, n, 0, 5'd3, 5'd0, 11'd0);
      waitTicks(4);
      sendWord(1, 0, 0, 0, {5'd3, 11'd0});
      sendData(n);
      waitTicks(2);
      sendWord(0, 0, 0, 0, 16'h1234);
      chk("R7 extra word ends at once", done, 1);
      chk("R7 too many errVec", errVec, 1 << B_WC);
    end

    // R4/R5: faults on a data word
    for (int f = 0; f < 2; f++) begin
      startMsg(0, 3, 0, 5'd12, 5'd0, 11'd0);
      waitTicks(2);
      sendWord(1, 0, 0, 0, {5'd12, 11'd0});
      sendData(1);
      waitTicks(2);
      sendWord(f == 0, f == 1, 0, 0, 16'hBEEF);
      sendData(1);
      waitDone("R5 data fault");
      chk(f == 0 ? "R4 data sync" : "R5 data manchester", errVec,
          f == 0 ? (1 << B_SYNC) : (1 << B_MAN));
    end

    // R8: status flag masking sweep
    for (int b = 0; b < 11; b++) begin
      startMsg(0, 0, 0, 5'd9, 5'd0, 11'd0);
      waitTicks(2);
      sendWord(1, 0, 0, 0, {5'd9, 11'(1 << b)});
      waitDone("R8 unmasked");
      chk("R8 unmasked flag", errVec, 1 << B_FLAG);
      startMsg(0, 0, 0, 5'd9, 5'd0, 11'(1 << b));
      waitTicks(2);
      sendWord(1, 0, 0, 0, {5'd9, 11'(1 << b)});
      waitDone("R8 masked");
      chk("R8 masked flag ignored", errVec, 0);
    end

    // R9: terminal-to-terminal transfers
    startMsg(1, 2, 1, 5'd9, 5'd20, 11'd0);
    waitTicks(3);
    sendWord(1, 0, 0, 0, {5'd20, 11'd0});
    sendData(2);
    waitTicks(3);
    sendWord(1, 0, 0, 0, {5'd9, 11'd0});
    waitDone("R9 good");
    chk("R9 good transfer", errVec, 0);

    startMsg(1, 2, 1, 5'd9, 5'd20, 11'd0);
    waitTicks(3);
    sendWord(1, 0, 0, 0, {5'd9, 11'd0});
    sendData(2);
    waitTicks(3);
    sendWord(1, 0, 0, 0, {5'd9, 11'd0});
    waitDone("R9 order");
    chk("R9 first status checked against sender", errVec, 1 << B_ADDR);

    startMsg(1, 2, 1, 5'd9, 5'd20, 11'd0);
    waitTicks(3);
    sendWord(1, 0, 0, 0, {5'd20, 11'd0});
    sendData(2);
    waitTicks(limOf(1) - 1);
    chk("R9 no second timeout early", done, 0);
    waitTicks(1);
    chk("R9 second timeout done", done, 1);
    chk("R9 second timeout bit", errVec, 1 << B_TO2);

    startMsg(1, 2, 1, 5'd9, 5'd20, 11'd0);
    waitTicks(3);
    sendWord(1, 0, 0, 0, {5'd20, 11'd0});
    sendData(2);
    waitTicks(3);
    sendWord(0, 0, 0, 0, {5'd9, 11'd0});
    waitDone("R9 second sync");
    chk("R4 second status sync", errVec, 1 << B_SYNC);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule